// File: doc/BRIEF.md
# Configuration Memory Unlock and Commit Guard

This block sits on a host register bus in front of a configuration memory. It keeps the memory closed to programming until the host writes a fixed five-byte sequence to a dedicated key register: a zero that arms the tracker, then four key bytes, one after another, with no other register access between them. Any other access cancels the attempt. A read, a write elsewhere, or an access from the on-chip sequencing state machine all count, and the arming zero must then be written again.

Once the guard is open, two status bits report it. The host may then disable the sequencing state machine, program a small protected page and start a commit of the register contents into the memory. A stub commit engine holds a busy flag for a fixed number of cycles. A lock byte in the configuration page closes the protected page and the commit path for good as soon as it holds anything other than its open code.

Top module: `nvm_guard`

## Requirements
- R1: After reset the guard is closed, the state-machine disable is 0, busy is 0, register 0xA3 of page 0 reads 0x00 and register 0x41 of page 1 reads 0xA5.
- R2: The writes 0x00, 0x98, 0xB8, 0x13, 0x7D to page 0 address 0xA2, with no other access between them, open the guard. Register 0xA3 then reads bits 7 and 6 set and the `unlocked` output is 1. Both stay set until reset.
- R3: A read, or a write to any other address, placed between the key writes cancels the sequence, and the remaining key bytes do not open the guard.
- R4: A pulse on `fsmAccess` during the sequence cancels it.
- R5: A wrong key byte, or key bytes written without the arming 0x00 first, leave the guard closed. Only a fresh 0x00 restarts the tracker.
- R6: Bit 0 of page 0 register 0xA3 drives `fsmDisable`. Writes to it are ignored while the guard is closed. After opening, writing 0xC1 makes the register read 0xC1.
- R7: Bits 7 and 6 of register 0xA3 are read-only. A host write of 0x00 to 0xA3 leaves them set.
- R8: With the guard open, writing a value with bit 1 set to page 1 register 0xEF raises `nvmBusy`. Bit 1 of 0xF3 and bit 1 of 0xEF then read 1 for exactly COPY_CYCLES cycles, and all three clear afterwards. The write is ignored while the guard is closed.
- R9: When page 1 register 0x41 holds a value other than 0xA5, the memory is locked. Commit starts are ignored, page 3 reads return 0, page 3 writes are ignored, and writes to 0x41 are ignored.
- R10: With the guard open and not locked, page 3 addresses below P3_DEPTH store written bytes and read them back. While the guard is closed, writes to page 3 are ignored.
- R11: Writes to page 1 register 0x41 are ignored while the guard is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busPage | input | 3 | Page number (0, 1 or 3 used) |
| busAddr | input | 8 | Register address within the page |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational, 0 when not reading |
| fsmAccess | input | 1 | Register access by the internal sequencing machine |
| unlocked | output | 1 | Guard open |
| fsmDisable | output | 1 | Sequencing machine disabled |
| nvmBusy | output | 1 | Commit in progress |

## Verification
The unlock tracker is driven with a clean key sequence and with sequences that are nearly correct: keys with no arming zero, one wrong byte, an interleaved read, a write to an unrelated address, and a state-machine pulse. Because these differ from the clean case in a single event, the bench can tell whether the tracker aborts on each kind of interference, rather than merely on a bad byte. Gated writes are each issued once with the guard closed and once with it open, so a missing gate shows as a visible register change. The commit flag is sampled in the last busy cycle and in the first idle cycle to pin down its length exactly. The lock is then set, and each protected path is tried again.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

  localparam logic [7:0] KEY_ADDR   = 8'hA2;
  localparam logic [7:0] STAT_ADDR  = 8'hA3;
  localparam logic [7:0] LOCK_ADDR  = 8'h41;
  localparam logic [7:0] START_ADDR = 8'hEF;
  localparam logic [7:0] BUSY_ADDR  = 8'hF3;
  localparam logic [7:0] OPEN_CODE  = 8'hA5;

  localparam logic [2:0] PAGE_CTL  = 3'd0;
  localparam logic [2:0] PAGE_CFG  = 3'd1;
  localparam logic [2:0] PAGE_PROT = 3'd3;

  typedef enum logic [2:0] {
    TRK_IDLE,
    TRK_ARMED,
    TRK_K1,
    TRK_K2,
    TRK_K3
  } trkState_t;

  typedef struct packed {
    logic setUnlock;
    logic fsmWr;
    logic copyStart;
    logic lockWr;
    logic protWr;
  } ctrlStrobe_t;

endpackage

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
  import nvm_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [2:0]  busPage,
  input  logic [7:0]  busAddr,
  input  logic [7:0]  busWdata,
  input  logic        fsmAccess,
  input  logic        unlocked,
  input  logic        locked,
  input  logic        busy,
  output ctrlStrobe_t strobe
);

  trkState_t stateQ, stateD;
  logic      wrHit, keyWr, keyMatch, lastKey;
  logic [7:0] expByte;

  assign wrHit = busValid && busWrite;
  assign keyWr = wrHit && (busPage == PAGE_CTL) && (busAddr == KEY_ADDR);

  always_comb begin
    case (stateQ)
      TRK_ARMED: expByte = 8'h98;
      TRK_K1:    expByte = 8'hB8;
      TRK_K2:    expByte = 8'h13;
      TRK_K3:    expByte = 8'h7D;
      default:   expByte = 8'h00;
    endcase
  end

  assign keyMatch = keyWr && (stateQ != TRK_IDLE) && (busWdata == expByte);
  assign lastKey  = keyMatch && (stateQ == TRK_K3) && !fsmAccess;

  always_comb begin
    stateD = stateQ;
    if (fsmAccess) begin
      stateD = TRK_IDLE;
    end else if (keyWr && busWdata == 8'h00) begin
      stateD = TRK_ARMED;
    end else if (busValid) begin
      if (keyMatch) begin
        case (stateQ)
          TRK_ARMED: stateD = TRK_K1;
          TRK_K1:    stateD = TRK_K2;
          TRK_K2:    stateD = TRK_K3;
          default:   stateD = TRK_IDLE;
        endcase
      end else begin
        stateD = TRK_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= TRK_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.setUnlock = lastKey;
    strobe.fsmWr     = wrHit && busPage == PAGE_CTL && busAddr == STAT_ADDR && unlocked;
    strobe.copyStart = wrHit && busPage == PAGE_CFG && busAddr == START_ADDR &&
                       busWdata[1] && unlocked && !locked && !busy;
    strobe.lockWr    = wrHit && busPage == PAGE_CFG && busAddr == LOCK_ADDR &&
                       unlocked && !locked;
    strobe.protWr    = wrHit && busPage == PAGE_PROT && unlocked && !locked;
  end

endmodule

// File: rtl/nvm_guard_dp.sv
module nvm_guard_dp
  import nvm_guard_pkg::*;
#(
  parameter int COPY_CYCLES = 16,
  parameter int P3_DEPTH    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [2:0]  busPage,
  input  logic [7:0]  busAddr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  output logic        unlocked,
  output logic        locked,
  output logic        busy,
  output logic        fsmDisable
);

  localparam int CNT_W = $clog2(COPY_CYCLES) + 1;
  localparam int P3_AW = (P3_DEPTH > 1) ? $clog2(P3_DEPTH) : 1;

  logic             unlockedQ, fsmDisQ, busyQ;
  logic [7:0]       lockByteQ;
  logic [CNT_W-1:0] cntQ;
  logic [7:0]       p3Q [P3_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockedQ <= 1'b0;
      fsmDisQ   <= 1'b0;
      lockByteQ <= OPEN_CODE;
    end else begin
      if (strobe.setUnlock) unlockedQ <= 1'b1;
      if (strobe.fsmWr)     fsmDisQ   <= busWdata[0];
      if (strobe.lockWr)    lockByteQ <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (strobe.copyStart) begin
      busyQ <= 1'b1;
      cntQ  <= CNT_W'(COPY_CYCLES - 1);
    end else if (busyQ) begin
      if (cntQ == '0) busyQ <= 1'b0;
      else            cntQ  <= cntQ - 1'b1;
    end
  end

  for (genvar i = 0; i < P3_DEPTH; i++) begin : g_prot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  p3Q[i] <= 8'h00;
      else if (strobe.protWr && busAddr == 8'(i)) p3Q[i] <= busWdata;
    end
  end

  assign unlocked   = unlockedQ;
  assign locked     = (lockByteQ != OPEN_CODE);
  assign busy       = busyQ;
  assign fsmDisable = fsmDisQ;

  always_comb begin
    busRdata = 8'h00;
    if (busValid && !busWrite) begin
      case (busPage)
        PAGE_CTL:
          if (busAddr == STAT_ADDR) busRdata = {unlockedQ, unlockedQ, 5'b0, fsmDisQ};
        PAGE_CFG:
          if (busAddr == LOCK_ADDR) busRdata = lockByteQ;
          else if (busAddr == START_ADDR || busAddr == BUSY_ADDR)
            busRdata = {6'b0, busyQ, 1'b0};
        PAGE_PROT:
          if (!locked && busAddr < 8'(P3_DEPTH)) busRdata = p3Q[busAddr[P3_AW-1:0]];
        default: busRdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/nvm_guard.sv
module nvm_guard
  import nvm_guard_pkg::*;
#(
  parameter int COPY_CYCLES = 16,
  parameter int P3_DEPTH    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busValid,
  input  logic       busWrite,
  input  logic [2:0] busPage,
  input  logic [7:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       fsmAccess,
  output logic       unlocked,
  output logic       fsmDisable,
  output logic       nvmBusy
);

  ctrlStrobe_t strobe;
  logic        locked;

  nvm_guard_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busPage(busPage), .busAddr(busAddr), .busWdata(busWdata),
    .fsmAccess(fsmAccess), .unlocked(unlocked), .locked(locked),
    .busy(nvmBusy), .strobe(strobe)
  );

  nvm_guard_dp #(.COPY_CYCLES(COPY_CYCLES), .P3_DEPTH(P3_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busValid(busValid),
    .busWrite(busWrite), .busPage(busPage), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .unlocked(unlocked),
    .locked(locked), .busy(nvmBusy), .fsmDisable(fsmDisable)
  );

endmodule

// File: rtl/nvm_guard_chk.sv
module nvm_guard_chk #(
  parameter int COPY_CYCLES = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       busValid,
  input logic       busWrite,
  input logic [2:0] busPage,
  input logic [7:0] busAddr,
  input logic [7:0] busWdata,
  input logic       fsmAccess,
  input logic       unlocked,
  input logic       fsmDisable,
  input logic       nvmBusy,
  input logic       locked
);

  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busyRun <= 0;
    else if (nvmBusy) busyRun <= busyRun + 1;
    else              busyRun <= 0;
  end

  p_unlock_last_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(busValid && busWrite && busPage == 3'd0 &&
                              busAddr == 8'hA2 && busWdata == 8'h7D));

  p_unlock_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |=> unlocked);

  p_fsm_abort_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> !$past(fsmAccess));

  p_fsm_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> !fsmDisable);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nvmBusy) |-> $past(busValid && busWrite && busPage == 3'd1 &&
                             busAddr == 8'hEF && busWdata[1] && unlocked));

  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= COPY_CYCLES);

  p_lock_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nvmBusy) |-> !$past(locked));

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

endmodule

bind nvm_guard nvm_guard_chk #(.COPY_CYCLES(COPY_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busPage(busPage), .busAddr(busAddr), .busWdata(busWdata),
  .fsmAccess(fsmAccess), .unlocked(unlocked), .fsmDisable(fsmDisable),
  .nvmBusy(nvmBusy), .locked(locked)
);

// File: tb/nvm_guard_tb_top.sv
`timescale 1ns/1ps
module nvm_guard_tb_top;

  localparam int COPY_CYCLES = 16;
  localparam int P3_DEPTH    = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busValid = 1'b0, busWrite = 1'b0, fsmAccess = 1'b0;
  logic [2:0] busPage = 3'd0;
  logic [7:0] busAddr = 8'h00, busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       unlocked, fsmDisable, nvmBusy;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } expItem_t;

  expItem_t sbQ[$];

  always #10 clk = ~clk;

  nvm_guard #(.COPY_CYCLES(COPY_CYCLES), .P3_DEPTH(P3_DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busPage(busPage), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .fsmAccess(fsmAccess), .unlocked(unlocked),
    .fsmDisable(fsmDisable), .nvmBusy(nvmBusy)
  );

  // monitor: compares each bus read against the queued expectation
  always @(negedge clk) begin
    if (rstN && busValid && !busWrite) begin
      nChecks++;
      if (sbQ.size() == 0) begin
        nFail++;
        $display("FAIL unexpected read: actual %02h expected none", busRdata);
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        if (busRdata !== it.exp) begin
          nFail++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, busRdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] pg, input logic [7:0] ad, input logic [7:0] d);
    busValid = 1'b1; busWrite = 1'b1; busPage = pg; busAddr = ad; busWdata = d;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdExp(input logic [2:0] pg, input logic [7:0] ad,
                       input logic [7:0] e, input string tag);
    expItem_t it;
    it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    busValid = 1'b1; busWrite = 1'b0; busPage = pg; busAddr = ad;
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic fsmPulse();
    fsmAccess = 1'b1;
    @(posedge clk); #1;
    fsmAccess = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chkOut(input string tag, input logic act, input logic e);
    nChecks++;
    if (act !== e) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, e);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    @(posedge clk); #1;
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    chkOut("R1 unlocked", unlocked, 1'b0);
    chkOut("R1 fsmDisable", fsmDisable, 1'b0);
    chkOut("R1 nvmBusy", nvmBusy, 1'b0);
    rdExp(3'd0, 8'hA3, 8'h00, "R1 status reg");
    rdExp(3'd1, 8'h41, 8'hA5, "R1 lock byte");

    // gated writes while closed
    wr(3'd0, 8'hA3, 8'hC1);
    rdExp(3'd0, 8'hA3, 8'h00, "R6 disable write while closed");
    wr(3'd1, 8'h41, 8'h00);
    rdExp(3'd1, 8'h41, 8'hA5, "R11 lock write while closed");
    wr(3'd1, 8'hEF, 8'h02);
    chkOut("R8 start while closed", nvmBusy, 1'b0);
    wr(3'd3, 8'h01, 8'h77);
    rdExp(3'd3, 8'h01, 8'h00, "R10 page3 write while closed");

    // R5 keys without arming zero
    wr(3'd0, 8'hA2, 8'h98); wr(3'd0, 8'hA2, 8'hB8);
    wr(3'd0, 8'hA2, 8'h13); wr(3'd0, 8'hA2, 8'h7D);
    rdExp(3'd0, 8'hA3, 8'h00, "R5 keys without zero");
    // R5 wrong byte, then the rest
    wr(3'd0, 8'hA2, 8'h00); wr(3'd0, 8'hA2, 8'h98); wr(3'd0, 8'hA2, 8'h11);
    wr(3'd0, 8'hA2, 8'hB8); wr(3'd0, 8'hA2, 8'h13); wr(3'd0, 8'hA2, 8'h7D);
    rdExp(3'd0, 8'hA3, 8'h00, "R5 wrong key byte");

    // R3 interleaved read
    wr(3'd0, 8'hA2, 8'h00); wr(3'd0, 8'hA2, 8'h98);
    rdExp(3'd0, 8'hA3, 8'h00, "R3 read inside sequence");
    wr(3'd0, 8'hA2, 8'hB8); wr(3'd0, 8'hA2, 8'h13); wr(3'd0, 8'hA2, 8'h7D);
    rdExp(3'd0, 8'hA3, 8'h00, "R3 aborted by read");
    // R3 interleaved write elsewhere
    wr(3'd0, 8'hA2, 8'h00); wr(3'd0, 8'hA2, 8'h98); wr(3'd0, 8'hA2, 8'hB8);
    wr(3'd0, 8'h10, 8'h55);
    wr(3'd0, 8'hA2, 8'h13); wr(3'd0, 8'hA2, 8'h7D);
    rdExp(3'd0, 8'hA3, 8'h00, "R3 aborted by other write");

    // R4 state-machine access
    wr(3'd0, 8'hA2, 8'h00); wr(3'd0, 8'hA2, 8'h98);
    fsmPulse();
    wr(3'd0, 8'hA2, 8'hB8); wr(3'd0, 8'hA2, 8'h13); wr(3'd0, 8'hA2, 8'h7D);
    chkOut("R4 aborted by fsm access", unlocked, 1'b0);
    rdExp(3'd0, 8'hA3, 8'h00, "R4 status after fsm abort");

    // R2 clean unlock
    wr(3'd0, 8'hA2, 8'h00); wr(3'd0, 8'hA2, 8'h98); wr(3'd0, 8'hA2, 8'hB8);
    wr(3'd0, 8'hA2, 8'h13); wr(3'd0, 8'hA2, 8'h7D);
    chkOut("R2 unlocked output", unlocked, 1'b1);
    rdExp(3'd0, 8'hA3, 8'hC0, "R2 status bits set");

    // R7 / R6
    wr(3'd0, 8'hA3, 8'h00);
    rdExp(3'd0, 8'hA3, 8'hC0, "R7 status bits read-only");
    wr(3'd0, 8'hA3, 8'hC1);
    rdExp(3'd0, 8'hA3, 8'hC1, "R6 disable bit set");
    chkOut("R6 fsmDisable output", fsmDisable, 1'b1);

    // R10 page3 storage
    wr(3'd3, 8'h01, 8'h5A);
    wr(3'd3, 8'h03, 8'hC3);
    rdExp(3'd3, 8'h01, 8'h5A, "R10 page3 entry 1");
    rdExp(3'd3, 8'h03, 8'hC3, "R10 page3 entry 3");

    // R8 commit timing
    wr(3'd1, 8'hEF, 8'h02);
    rdExp(3'd1, 8'hF3, 8'h02, "R8 busy bit during commit");
    rdExp(3'd1, 8'hEF, 8'h02, "R8 start bit during commit");
    idle(COPY_CYCLES - 3);
    chkOut("R8 busy in last cycle", nvmBusy, 1'b1);
    idle(1);
    chkOut("R8 busy cleared", nvmBusy, 1'b0);
    rdExp(3'd1, 8'hF3, 8'h00, "R8 busy bit cleared");
    rdExp(3'd1, 8'hEF, 8'h00, "R8 start bit cleared");

    // R9 permanent lock
    wr(3'd1, 8'h41, 8'h00);
    rdExp(3'd1, 8'h41, 8'h00, "R9 lock byte written");
    wr(3'd1, 8'h41, 8'hA5);
    rdExp(3'd1, 8'h41, 8'h00, "R9 lock byte frozen");
    wr(3'd1, 8'hEF, 8'h02);
    chkOut("R9 commit refused", nvmBusy, 1'b0);
    rdExp(3'd3, 8'h01, 8'h00, "R9 page3 read blocked");
    wr(3'd3, 8'h02, 8'h99);
    rdExp(3'd3, 8'h02, 8'h00, "R9 page3 write blocked");

    idle(2);
    if (sbQ.size() != 0) begin
      nChecks++;
      nFail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbQ.size());
    end
    finishRun();
  end

endmodule